// File: doc/BRIEF.md
# Block-TLB Maintenance Command Unit

This unit executes maintenance requests against a small table of block translation entries. Each request carries an option number and a set of argument words: a virtual page split into a high and a low word, a physical page, a length in pages, a slot number and a protection word. The unit can report the block-table geometry, build and install a variable-length block entry into a chosen slot, force-purge one slot, or force-purge every slot. It returns a signed 32-bit status code for every request.

The entry storage is outside the block. The unit drives a flush strobe and a write strobe, together with the slot index and the fully formed entry contents, into that storage. A request is taken when `cmd_valid_i` is high while the unit is idle. `busy_o` stays high until the request completes, and `done_o` marks the final cycle. Purging all slots walks the slots with one flush per cycle.

Top module: `btlb_maint_unit`

## Requirements
- R1: Synchronous active-low reset clears `busy_o`, `done_o`, both strobes, `status_o` and the four info words to zero. Reset also aborts a running request.
- R2: Option 0 completes one cycle after acceptance with status 0. It loads the info words with 1, 16384, FIXED_SLOTS and VAR_SLOTS on `info0_o`..`info3_o`, and it raises no strobe.
- R3: Option 1 with a valid slot raises `ent_flush_o` for that slot in the first cycle after acceptance. It raises `ent_wr_o` for the same slot in the second cycle, together with `done_o`, and status is 0.
- R4: On an insert write, `ent_va_begin_o` is the 64-bit value {vpage_hi, vpage_lo} shifted left by PAGE_BITS and truncated to VA_W. `ent_va_end_o` is begin + (npages << PAGE_BITS) - 1, modulo 2^VA_W. `ent_pa_base_o` is ppage << PAGE_BITS, truncated to PA_W.
- R5: On an insert write, the protection word is decoded as follows: bits [18:1] form the access id, bit 19 is the user flag, bits [21:20] are the write privilege limit, bits [23:22] are the read privilege limit, bits [26:24] are the access type and bit 27 is the break flag. The dirty flag is always driven to 1 and the trap flag to 0, whatever bits 28 and 29 hold.
- R6: Option 2 with a valid slot raises exactly one flush for that slot, in the first cycle after acceptance, together with `done_o`, and status is 0.
- R7: Option 3 flushes slots 0, 1, … N-1 (N = FIXED_SLOTS+VAR_SLOTS) in ascending order, one per cycle, starting the first cycle after acceptance. `done_o` comes with the last flush, status is 0, and the slot argument is ignored.
- R8: Options 1 and 2 with slot ≥ N return status -10 (0xFFFFFFF6) one cycle after acceptance and raise no strobe.
- R9: Any option above 3 returns status -2 (0xFFFFFFFE) one cycle after acceptance and raises no strobe. Options 0 and 3 ignore the slot argument.
- R10: `cmd_valid_i` while `busy_o` is high is ignored. The running sequence, its strobes and its status are unchanged, and no second request starts afterwards.
- R11: `busy_o` is high from the cycle after acceptance through the `done_o` cycle and low after it. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | Request strobe, taken when idle |
| opt_i | input | 32 | Option number |
| vpage_hi_i | input | 32 | Virtual page, upper word |
| vpage_lo_i | input | 32 | Virtual page, lower word |
| ppage_i | input | 32 | Physical page |
| npages_i | input | 32 | Length in pages |
| slot_i | input | 32 | Target slot |
| prot_i | input | 32 | Protection word |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Final cycle of a request |
| status_o | output | 32 | Signed status code |
| info0_o | output | 32 | Info word 0 |
| info1_o | output | 32 | Info word 1 |
| info2_o | output | 32 | Info word 2 (fixed-slot count) |
| info3_o | output | 32 | Info word 3 (variable-slot count) |
| ent_flush_o | output | 1 | Force-flush strobe to entry storage |
| ent_wr_o | output | 1 | Write strobe to entry storage |
| ent_slot_o | output | $clog2(N) | Slot addressed by the strobes |
| ent_va_begin_o | output | VA_W | First virtual byte covered |
| ent_va_end_o | output | VA_W | Last virtual byte covered |
| ent_pa_base_o | output | PA_W | Physical base address |
| ent_acc_id_o | output | 18 | Access id |
| ent_user_o | output | 1 | User flag |
| ent_pl_wr_o | output | 2 | Write privilege limit |
| ent_pl_rd_o | output | 2 | Read privilege limit |
| ent_ar_type_o | output | 3 | Access type |
| ent_brk_o | output | 1 | Break flag |
| ent_dirty_o | output | 1 | Dirty flag (forced 1) |
| ent_trap_o | output | 1 | Trap flag (forced 0) |

## Verification
The bench builds the unit with FIXED_SLOTS=3 and VAR_SLOTS=2, so N=5 is not a power of two. That puts slot 4, the last legal slot, and slot 5, the first rejected slot, next to each other, and it lets the sweep be checked in full without the counter's natural wrap hiding an off-by-one. The default VA_W=64 and PAGE_BITS=12 let a high virtual word with its top bits set show the truncation of the shifted page. A zero page count shows the end address landing one below the begin address.

// File: rtl/btlb_maint_pkg.sv
// Package: shared types and constants for the block-TLB maintenance unit.
// Assumes 32-bit argument words and the fixed protection-word bit layout.
package btlb_maint_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_INS_FLUSH,
        SQ_INS_WRITE,
        SQ_ONE_FLUSH,
        SQ_SWEEP,
        SQ_REPLY
    } seq_state_e;

    localparam logic [31:0] ST_OK      = 32'h0000_0000;
    localparam logic [31:0] ST_BAD_ARG = 32'hFFFF_FFF6;  // -10
    localparam logic [31:0] ST_NO_OPT  = 32'hFFFF_FFFE;  // -2

    localparam logic [31:0] INFO_WORD0 = 32'd1;
    localparam logic [31:0] INFO_WORD1 = 32'd16384;

    typedef struct packed {
        logic [17:0] acc_id;
        logic        user;
        logic [1:0]  pl_wr;
        logic [1:0]  pl_rd;
        logic [2:0]  ar_type;
        logic        brk;
        logic        dirty;
        logic        trap;
    } prot_t;

    // Decode the protection word; dirty forced set, trap forced clear.
    function automatic prot_t decode_prot(input logic [27:1] w);
        prot_t p;
        p.acc_id  = w[18:1];
        p.user    = w[19];
        p.pl_wr   = w[21:20];
        p.pl_rd   = w[23:22];
        p.ar_type = w[26:24];
        p.brk     = w[27];
        p.dirty   = 1'b1;
        p.trap    = 1'b0;
        return p;
    endfunction

endpackage

// File: rtl/btlb_cmd_decode.sv
// Command decoder: maps an option number and slot argument onto the
// sequencer's first state and the status code to return.
// Assumes it is sampled only in the cycle a request is accepted.
module btlb_cmd_decode
    import btlb_maint_pkg::*;
#(
    parameter int N_SLOTS = 12
) (
    input  logic [31:0] opt_i,
    input  logic [31:0] slot_i,
    output seq_state_e  first_state_o,
    output logic [31:0] status_o,
    output logic        is_info_o
);

    logic slot_ok;

    // Range check of the slot argument against the table size.
    always_comb slot_ok = (slot_i < 32'(N_SLOTS));

    // Option dispatch.
    always_comb begin
        first_state_o = SQ_REPLY;
        status_o      = ST_OK;
        is_info_o     = 1'b0;
        case (opt_i)
            32'd0: is_info_o = 1'b1;
            32'd1: begin
                if (slot_ok) first_state_o = SQ_INS_FLUSH;
                else         status_o      = ST_BAD_ARG;
            end
            32'd2: begin
                if (slot_ok) first_state_o = SQ_ONE_FLUSH;
                else         status_o      = ST_BAD_ARG;
            end
            32'd3:   first_state_o = SQ_SWEEP;
            default: status_o      = ST_NO_OPT;
        endcase
    end

endmodule

// File: rtl/btlb_entry_build.sv
// Entry builder: forms the virtual range, physical base and decoded
// protection fields from page-granular arguments held for an insert.
// Assumes VA_W <= 64+PAGE_BITS and PA_W <= 32+PAGE_BITS.
module btlb_entry_build
    import btlb_maint_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic [31:0]     vhi_i,
    input  logic [31:0]     vlo_i,
    input  logic [31:0]     ppage_i,
    input  logic [31:0]     npages_i,
    input  logic [31:0]     prot_i,
    output logic [VA_W-1:0] va_begin_o,
    output logic [VA_W-1:0] va_end_o,
    output logic [PA_W-1:0] pa_base_o,
    output prot_t           prot_o
);

    localparam int VW = 64 + PAGE_BITS;
    localparam int PW = 32 + PAGE_BITS;

    logic [VW-1:0]   vshift;
    logic [PW-1:0]   pshift;
    logic [VA_W-1:0] span;
    logic            unused_bits;

    // Page-to-byte conversion of the virtual and physical bases.
    always_comb begin
        vshift = VW'({vhi_i, vlo_i}) << PAGE_BITS;
        pshift = PW'(ppage_i) << PAGE_BITS;
    end

    // Length in bytes and the inclusive range.
    always_comb begin
        span       = VA_W'(npages_i) << PAGE_BITS;
        va_begin_o = vshift[VA_W-1:0];
        va_end_o   = va_begin_o + span - VA_W'(1);
        pa_base_o  = pshift[PA_W-1:0];
    end

    // Protection field decode.
    always_comb prot_o = decode_prot(prot_i[27:1]);

    // Fold of bits that carry no meaning here.
    always_comb unused_bits = ^{vshift, pshift, prot_i[31:28], prot_i[0]};

endmodule

// File: rtl/btlb_sweep_ctr.sv
// Sweep counter: steps through slot indices 0..N-1 for purge-all.
// Assumes N_SLOTS >= 2; clear has priority over step.
module btlb_sweep_ctr #(
    parameter int N_SLOTS = 12,
    localparam int IW = $clog2(N_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [IW-1:0] count_o,
    output logic          last_o
);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_o <= '0;
        else if (clear_i) count_o <= '0;
        else if (step_i)  count_o <= count_o + IW'(1);
    end

    // Final-slot detect.
    always_comb last_o = (count_o == IW'(N_SLOTS - 1));

endmodule

// File: rtl/btlb_seq.sv
// Sequencer: orders flush, write and completion for each request and
// holds busy until the request finishes.
// Assumes start_i is raised only while idle.
module btlb_seq
    import btlb_maint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  seq_state_e start_state_i,
    input  logic       sweep_last_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       flush_o,
    output logic       wr_o,
    output logic       sweep_o
);

    seq_state_e state_q;

    // State register and transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else begin
            case (state_q)
                SQ_IDLE:      if (start_i) state_q <= start_state_i;
                SQ_INS_FLUSH: state_q <= SQ_INS_WRITE;
                SQ_SWEEP:     if (sweep_last_i) state_q <= SQ_IDLE;
                default:      state_q <= SQ_IDLE;
            endcase
        end
    end

    // Strobe and status flags from the current state.
    always_comb begin
        busy_o  = (state_q != SQ_IDLE);
        sweep_o = (state_q == SQ_SWEEP);
        wr_o    = (state_q == SQ_INS_WRITE);
        flush_o = (state_q == SQ_INS_FLUSH) || (state_q == SQ_ONE_FLUSH) || sweep_o;
        done_o  = wr_o || (state_q == SQ_ONE_FLUSH) || (state_q == SQ_REPLY)
                  || (sweep_o && sweep_last_i);
    end

    // R3
    ins_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> $past(flush_o));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: rtl/btlb_maint_unit.sv
// Top: block-TLB maintenance command unit. Accepts a request when idle,
// latches its arguments, and drives flush/write strobes plus entry
// contents toward external entry storage; returns a signed status.
// Assumes FIXED_SLOTS+VAR_SLOTS >= 2.
module btlb_maint_unit
    import btlb_maint_pkg::*;
#(
    parameter int FIXED_SLOTS = 8,
    parameter int VAR_SLOTS   = 4,
    parameter int VA_W        = 64,
    parameter int PA_W        = 32,
    parameter int PAGE_BITS   = 12,
    localparam int N_SLOTS    = FIXED_SLOTS + VAR_SLOTS,
    localparam int IW         = $clog2(N_SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid_i,
    input  logic [31:0]     opt_i,
    input  logic [31:0]     vpage_hi_i,
    input  logic [31:0]     vpage_lo_i,
    input  logic [31:0]     ppage_i,
    input  logic [31:0]     npages_i,
    input  logic [31:0]     slot_i,
    input  logic [31:0]     prot_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [31:0]     status_o,
    output logic [31:0]     info0_o,
    output logic [31:0]     info1_o,
    output logic [31:0]     info2_o,
    output logic [31:0]     info3_o,
    output logic            ent_flush_o,
    output logic            ent_wr_o,
    output logic [IW-1:0]   ent_slot_o,
    output logic [VA_W-1:0] ent_va_begin_o,
    output logic [VA_W-1:0] ent_va_end_o,
    output logic [PA_W-1:0] ent_pa_base_o,
    output logic [17:0]     ent_acc_id_o,
    output logic            ent_user_o,
    output logic [1:0]      ent_pl_wr_o,
    output logic [1:0]      ent_pl_rd_o,
    output logic [2:0]      ent_ar_type_o,
    output logic            ent_brk_o,
    output logic            ent_dirty_o,
    output logic            ent_trap_o
);

    logic        accept;
    seq_state_e  first_state;
    logic [31:0] first_status;
    logic        is_info;
    logic        sweep_act, sweep_last;
    logic [IW-1:0] sweep_idx;

    logic [31:0] vhi_q, vlo_q, ppage_q, npages_q, prot_q;
    logic [IW-1:0] slot_q;
    logic [31:0] status_q;
    logic        unused_slot_hi;
    prot_t       prot_dec;

    // Request acceptance.
    always_comb accept = cmd_valid_i && !busy_o;

    btlb_cmd_decode #(.N_SLOTS(N_SLOTS)) u_dec (
        .opt_i         (opt_i),
        .slot_i        (slot_i),
        .first_state_o (first_state),
        .status_o      (first_status),
        .is_info_o     (is_info)
    );

    btlb_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (accept),
        .start_state_i (first_state),
        .sweep_last_i  (sweep_last),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .flush_o       (ent_flush_o),
        .wr_o          (ent_wr_o),
        .sweep_o       (sweep_act)
    );

    btlb_sweep_ctr #(.N_SLOTS(N_SLOTS)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (sweep_act),
        .count_o (sweep_idx),
        .last_o  (sweep_last)
    );

    // Argument capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vhi_q    <= '0;
            vlo_q    <= '0;
            ppage_q  <= '0;
            npages_q <= '0;
            prot_q   <= '0;
            slot_q   <= '0;
        end else if (accept) begin
            vhi_q    <= vpage_hi_i;
            vlo_q    <= vpage_lo_i;
            ppage_q  <= ppage_i;
            npages_q <= npages_i;
            prot_q   <= prot_i;
            slot_q   <= slot_i[IW-1:0];
        end
    end

    // Status register, loaded when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      status_q <= ST_OK;
        else if (accept) status_q <= first_status;
    end

    // Info words, loaded by the parameter-report option.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info0_o <= '0;
            info1_o <= '0;
            info2_o <= '0;
            info3_o <= '0;
        end else if (accept && is_info) begin
            info0_o <= INFO_WORD0;
            info1_o <= INFO_WORD1;
            info2_o <= 32'(FIXED_SLOTS);
            info3_o <= 32'(VAR_SLOTS);
        end
    end

    btlb_entry_build #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_build (
        .vhi_i      (vhi_q),
        .vlo_i      (vlo_q),
        .ppage_i    (ppage_q),
        .npages_i   (npages_q),
        .prot_i     (prot_q),
        .va_begin_o (ent_va_begin_o),
        .va_end_o   (ent_va_end_o),
        .pa_base_o  (ent_pa_base_o),
        .prot_o     (prot_dec)
    );

    // Entry output fan-out and slot selection.
    always_comb begin
        status_o      = status_q;
        ent_slot_o    = sweep_act ? sweep_idx : slot_q;
        ent_acc_id_o  = prot_dec.acc_id;
        ent_user_o    = prot_dec.user;
        ent_pl_wr_o   = prot_dec.pl_wr;
        ent_pl_rd_o   = prot_dec.pl_rd;
        ent_ar_type_o = prot_dec.ar_type;
        ent_brk_o     = prot_dec.brk;
        ent_dirty_o   = prot_dec.dirty;
        ent_trap_o    = prot_dec.trap;
    end

    // Fold of slot bits above the index width.
    always_comb unused_slot_hi = ^slot_i;

    // R11
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cmd_valid_i));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o != ST_OK) |-> (!ent_wr_o && !ent_flush_o));

    // R10
    ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(done_o)) |-> $stable(status_o));

    // R7
    sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_act && $past(sweep_act)) |-> (ent_slot_o == $past(ent_slot_o) + IW'(1)));

endmodule

// File: tb/btlb_maint_unit_test.sv
module btlb_maint_unit_test;

    localparam int FS = 3;
    localparam int VS = 2;
    localparam int N  = FS + VS;
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [31:0] opt;
        logic [31:0] slot;
        logic [31:0] vhi;
        logic [31:0] vlo;
        logic [31:0] pp;
        logic [31:0] len;
        logic [31:0] prot;
        logic [31:0] st;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{32'd0, 32'd0,  32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'h0},
        '{32'd1, 32'd2,  32'd1, 32'h0001_2345, 32'h000A_BCDE, 32'd3, 32'h3FFF_FFFE, 32'h0},
        '{32'd1, 32'd4,  32'hFFFF_F000, 32'hFFFF_FFFF, 32'h0000_0001, 32'd1, 32'h00A5_A5A4, 32'h0},
        '{32'd1, 32'd5,  32'd7, 32'd7, 32'd7, 32'd7, 32'hFFFF_FFFF, 32'hFFFF_FFF6},
        '{32'd2, 32'd0,  32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'h0},
        '{32'd2, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'hFFFF_FFF6},
        '{32'd3, 32'd77, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'h0},
        '{32'd4, 32'd1,  32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'hFFFF_FFFE},
        '{32'h8000_0000, 32'd1, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'hFFFF_FFFE},
        '{32'd0, 32'd99, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'h0},
        '{32'd1, 32'd1,  32'd0, 32'h0000_0010, 32'h0000_0020, 32'd0, 32'h1000_0002, 32'h0}
    };

    logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
    logic [31:0] opt = '0, vhi = '0, vlo = '0, pp = '0, len = '0, slot = '0, prot = '0;
    logic busy, done, e_flush, e_wr, e_user, e_brk, e_dirty, e_trap;
    logic [31:0] status, i0, i1, i2, i3;
    logic [IW-1:0] e_slot;
    logic [63:0] e_beg, e_end;
    logic [31:0] e_pa;
    logic [17:0] e_id;
    logic [1:0] e_plw, e_plr;
    logic [2:0] e_type;

    int checks = 0, fails = 0;
    bit wd_hit = 1'b0;

    always #10 clk = ~clk;

    btlb_maint_unit #(.FIXED_SLOTS(FS), .VAR_SLOTS(VS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .opt_i(opt),
        .vpage_hi_i(vhi), .vpage_lo_i(vlo), .ppage_i(pp), .npages_i(len),
        .slot_i(slot), .prot_i(prot), .busy_o(busy), .done_o(done),
        .status_o(status), .info0_o(i0), .info1_o(i1), .info2_o(i2), .info3_o(i3),
        .ent_flush_o(e_flush), .ent_wr_o(e_wr), .ent_slot_o(e_slot),
        .ent_va_begin_o(e_beg), .ent_va_end_o(e_end), .ent_pa_base_o(e_pa),
        .ent_acc_id_o(e_id), .ent_user_o(e_user), .ent_pl_wr_o(e_plw),
        .ent_pl_rd_o(e_plr), .ent_ar_type_o(e_type), .ent_brk_o(e_brk),
        .ent_dirty_o(e_dirty), .ent_trap_o(e_trap)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one vector, record strobes per cycle, check against expectations.
    task automatic run_vec(input vec_t v);
        int nfl = 0, nwr = 0, cyc = 0, fl_cyc = 0, wr_cyc = 0;
        logic [IW-1:0] fl_slot = '0, wr_slot = '0;
        logic [63:0] beg = '0, en = '0;
        logic [31:0] pa = '0;
        logic [31:0] fields = '0;
        bit seq_ok = 1'b1, busy_ok = 1'b1;
        logic [63:0] xb, xe;
        logic [31:0] xf;
        @(negedge clk);
        opt = v.opt; slot = v.slot; vhi = v.vhi; vlo = v.vlo;
        pp = v.pp; len = v.len; prot = v.prot; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 1; c < 40; c++) begin
            cyc = c;
            if (!busy) busy_ok = 1'b0;
            if (e_flush) begin
                if (v.opt == 32'd3 && e_slot != IW'(nfl)) seq_ok = 1'b0;
                nfl++; fl_cyc = c; fl_slot = e_slot;
            end
            if (e_wr) begin
                nwr++; wr_cyc = c; wr_slot = e_slot;
                beg = e_beg; en = e_end; pa = e_pa;
                fields = {e_trap, e_dirty, e_brk, e_type, e_plr, e_plw, e_user, e_id, 1'b0};
            end
            if (done) break;
            @(negedge clk);
        end
        chk(busy_ok, "R11", "busy held through request", 64'(busy_ok), 64'd1);
        chk(status == v.st, (v.st == 32'hFFFF_FFF6) ? "R8" : (v.st == 32'hFFFF_FFFE) ? "R9" : "R3",
            "status", 64'(status), 64'(v.st));
        @(negedge clk);
        chk(!busy && !done, "R11", "idle after done", {busy, done}, 64'd0);
        if (v.st != 32'h0) begin
            chk(nfl == 0 && nwr == 0, "R8", "no strobes on error", 64'(nfl + nwr), 64'd0);
            chk(cyc == 1, "R9", "error reply latency", 64'(cyc), 64'd1);
        end else begin
            case (v.opt)
                32'd0: begin
                    chk(nfl == 0 && nwr == 0 && cyc == 1, "R2", "info no strobes", 64'(nfl + nwr), 64'd0);
                    chk({i0, i1} == {32'd1, 32'd16384}, "R2", "info0/1", {i0, i1}, {32'd1, 32'd16384});
                    chk({i2, i3} == {32'(FS), 32'(VS)}, "R2", "info2/3", {i2, i3}, {32'(FS), 32'(VS)});
                end
                32'd1: begin
                    chk(nfl == 1 && fl_cyc == 1 && fl_slot == IW'(v.slot), "R3", "flush before write",
                        {32'(fl_cyc), 32'(fl_slot)}, {32'd1, v.slot});
                    chk(nwr == 1 && wr_cyc == 2 && cyc == 2 && wr_slot == IW'(v.slot), "R3", "write cycle",
                        {32'(wr_cyc), 32'(wr_slot)}, {32'd2, v.slot});
                    xb = {v.vhi, v.vlo} << 12;
                    xe = xb + ({32'd0, v.len} << 12) - 64'd1;
                    chk(beg == xb, "R4", "va begin", beg, xb);
                    chk(en == xe, "R4", "va end", en, xe);
                    chk(pa == (v.pp << 12), "R4", "pa base", 64'(pa), 64'(v.pp << 12));
                    xf = {2'b00, 1'b0, 1'b1, v.prot[27:1], 1'b0};
                    chk(fields == xf, "R5", "protection fields", 64'(fields), 64'(xf));
                end
                32'd2: chk(nfl == 1 && cyc == 1 && fl_slot == IW'(v.slot), "R6", "single purge",
                           {32'(nfl), 32'(fl_slot)}, {32'd1, v.slot});
                default: begin
                    chk(seq_ok && nfl == N && cyc == N && nwr == 0, "R7", "sweep sequence",
                        {32'(nfl), 32'(cyc)}, {32'(N), 32'(N)});
                end
            endcase
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !e_flush && !e_wr && status == 0, "R1", "reset outputs",
            {busy, done, e_flush, e_wr, status}, 64'd0);
        chk({i0, i1, i2, i3} == '0, "R1", "reset info", 64'(i0 | i1 | i2 | i3), 64'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R10: request during a sweep is ignored
        begin
            int nfl = 0, nwr = 0, cyc = 0;
            bit order_ok = 1'b1;
            @(negedge clk);
            opt = 32'd3; slot = '0; cmd_valid = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            for (int c = 1; c < 40; c++) begin
                cyc = c;
                if (c == 2) begin opt = 32'd1; slot = 32'd1; cmd_valid = 1'b1; end
                if (c == 3) cmd_valid = 1'b0;
                if (e_flush) begin
                    if (e_slot != IW'(nfl)) order_ok = 1'b0;
                    nfl++;
                end
                if (e_wr) nwr++;
                if (done) break;
                @(negedge clk);
            end
            chk(order_ok && nfl == N && nwr == 0 && cyc == N, "R10", "busy request ignored",
                {32'(nfl), 32'(nwr)}, {32'(N), 32'd0});
            chk(status == 0, "R10", "status kept", 64'(status), 64'd0);
            @(negedge clk);
            chk(!busy && !e_wr, "R10", "no late start", {busy, e_wr}, 64'd0);
        end

        // R1: reset aborts a running sweep
        @(negedge clk);
        opt = 32'd3; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !e_flush && !done && status == 0 && i0 == 0, "R1", "mid-sweep reset",
            {busy, e_flush, done, status}, 64'd0);
        rst_n = 1'b1;
        run_vec(VEC[4]);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        wd_hit = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule